// File: doc/BRIEF.md
# Video Output Control Register Unit

This unit is the control and status register block of a video output engine. Software reaches it over a simple register bus with a write strobe, a read strobe and a small word address. The unit holds the engine configuration and drives it to the rest of the engine as plain signals. That configuration covers the operating mode, the source for the pixel clock, the ratios for two PLL dividers, the direction of the clock pin and the two sync pins, the active edge of the external frame reference, and an overlay enable. The unit runs in the video clock domain.

The unit also keeps four sticky flags. Two are "buffer empty" flags, one for each transfer buffer. The other two are a horizontal-blank error flag and an underrun flag. The datapath sets these flags with one-cycle pulses. Software clears them with write-one acknowledge bits, and each flag drives an interrupt line. In streaming mode, an enable write acknowledges both buffers. In message mode, it acknowledges only the first buffer.

A software reset bit in the control word clears the flags and holds the engine off, but it leaves the stored configuration as it was. The engine enable then takes effect only after a fixed number of clock cycles has passed since the reset bit was released.

Top module: `vout_ctrl_regs`

## Requirements
- R1: A synchronous active-low reset makes the control word read 0x32400000, the enable word read 0, and the status word read 0x13. It also drives clk_sel=3, both divider ratios to 2, and clk_pin_oe, io_pins_oe and soft_rst to 0.
- R2: The control word lives at address 0. Its fields are:
  - bit 31: soft reset
  - bit 30: sleepless
  - bits 29:28: clock select
  - bits 27:25: input divider
  - bits 24:22: feedback divider
  - bit 21: clock-out
  - bit 20: sync master
  - bit 19: pin-1 polarity
  - bit 18: pin-2 polarity
  - bit 17: overlay enable
  - bits 16:13: mode

  Every field reads back as written. Bits 12:0 always read 0, including the acknowledge bits 3:0.
- R3: pll_in_ratio equals the input divider field plus 1, and pll_fb_ratio equals the feedback divider field plus 1. clk_sel equals the clock select field (0 VCO, 1 feedback divider, 2 input divider, 3 direct synthesizer). pll_bypass is 1 exactly when clock select is 3.
- R4: clk_pin_oe follows the clock-out bit, and io_pins_oe follows the sync-master bit.
- R5: While sync master is 0, frame_ref pulses for one cycle on an io2_in transition. The pin-2 polarity bit chooses the transition: 1 selects rising and 0 selects falling. While sync master is 1, frame_ref stays 0.
- R6: The soft reset bit leaves every other control field as it was written. While the bit is 1, soft_rst is 1, engine_en is 0, all four flags hold their reset values (buffers empty, errors clear), and events and acknowledges are ignored.
- R7: engine_en equals the enable bit (address 1, bit 0) gated by stabilization. After the write that clears soft reset, engine_en stays 0 for STAB_CYCLES-1 cycles and rises in cycle STAB_CYCLES (5 by default). An enable written earlier is held until then. Status bit 4 reads 1 once stabilization has ended.
- R8: Writing 1 to control bit 0 clears buffer-1 empty, and writing 1 to control bit 1 clears buffer-2 empty. A 0 in these bits has no effect. Status bits 0 and 1 show the two flags.
- R9: Writing 1 to the enable bit clears both buffer-empty flags in streaming mode (mode 5). It clears only buffer 1 in message mode (mode 4). It clears no flag in any other mode.
- R10: In message mode, the buffer-2 acknowledge bit is ignored.
- R11: A pulse on hbe_evt sets the HBE flag (status bit 2, irq_hbe), and a pulse on urun_evt sets the underrun flag (status bit 3, irq_urun). Control bits 2 and 3 clear them, and an acknowledge wins over an event in the same cycle.
- R12: A pulse on buf_done[i] sets buffer i's empty flag. An acknowledge in the same cycle wins.
- R13: irq_buf[i] is 1 when buffer i is empty and engine_en is 1.
- R14: Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (rdata is 0 otherwise) |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| buf_done | input | 2 | Buffer transfer completion pulses |
| hbe_evt | input | 1 | Horizontal-blank error pulse |
| urun_evt | input | 1 | Underrun pulse |
| io2_in | input | 1 | Frame reference pin level, synchronous |
| mode | output | 4 | Operating mode |
| clk_sel | output | 2 | Pixel clock source select |
| pll_bypass | output | 1 | Direct synthesizer clock selected |
| pll_in_ratio | output | 4 | Input divider ratio |
| pll_fb_ratio | output | 4 | Feedback divider ratio |
| clk_pin_oe | output | 1 | Clock pin drive enable |
| io_pins_oe | output | 1 | Sync pins drive enable |
| overlay_en | output | 1 | Overlay enable |
| sleepless | output | 1 | Power-down inhibit |
| soft_rst | output | 1 | Engine soft reset |
| engine_en | output | 1 | Effective engine enable |
| frame_ref | output | 1 | Detected frame reference edge |
| buf_empty | output | 2 | Buffer empty flags |
| irq_buf | output | 2 | Buffer interrupts |
| irq_hbe | output | 1 | HBE interrupt |
| irq_urun | output | 1 | Underrun interrupt |

## Verification
Some properties are checked on every cycle:
- The enable can never rise before the stabilization window since the last soft reset release has passed.
- An acknowledge always clears its flag even when a completion pulse arrives at the same time.
- A buffer flag rises only after a completion pulse or a soft reset.
- In message mode, nothing clears the second buffer flag.
- The clock and pin outputs come out of hardware reset in their input-state defaults.

Other behaviours need the bench's scenarios to show them:
- Every field reads back exactly as written.
- The divider ratios and the clock source decode correctly.
- Each polarity and master setting picks the right frame reference edge.
- Flags return to their reset values during soft reset.
- The three-way choice of what an enable write acknowledges depends on the mode.

// File: rtl/vout_pkg.sv
// Package: shared field layout, reset values, mode codes and flag indices
// for the video output control register unit.
package vout_pkg;

    localparam int REG_W     = 32;
    localparam int CFG_LSB   = 13;   // configuration fields occupy bits 31:13
    localparam int NFLAG     = 4;

    // Register word addresses
    localparam int REG_CTL   = 0;
    localparam int REG_EN    = 1;
    localparam int REG_STAT  = 2;

    // Acknowledge bit positions in the control word (write-only)
    localparam int ACK_BUF1  = 0;
    localparam int ACK_BUF2  = 1;
    localparam int ACK_HBE   = 2;
    localparam int ACK_URUN  = 3;

    // Flag indices
    localparam int FLG_BUF1  = 0;
    localparam int FLG_BUF2  = 1;
    localparam int FLG_HBE   = 2;
    localparam int FLG_URUN  = 3;
    localparam logic [NFLAG-1:0] FLAG_RESET = 4'b0011;

    // Mode codes with special acknowledge behaviour
    localparam logic [3:0] MODE_MSG    = 4'd4;
    localparam logic [3:0] MODE_STREAM = 4'd5;

    typedef enum logic [1:0] {
        CSRC_VCO  = 2'd0,
        CSRC_FBD  = 2'd1,
        CSRC_IND  = 2'd2,
        CSRC_SYNT = 2'd3
    } vout_csrc_e;

    // Packed so that bit 31 of the control word is srst and bit 13 is mode[0]
    typedef struct packed {
        logic       srst;
        logic       sleepless;
        vout_csrc_e csel;
        logic [2:0] idiv;
        logic [2:0] fdiv;
        logic       clkout;
        logic       syncm;
        logic       pol1;
        logic       pol2;
        logic       ovl;
        logic [3:0] mode;
    } vout_cfg_t;

    localparam int CFG_W = $bits(vout_cfg_t);

    localparam vout_cfg_t CFG_HW_DEFAULT = '{
        srst: 1'b0, sleepless: 1'b0, csel: CSRC_SYNT, idiv: 3'd1, fdiv: 3'd1,
        clkout: 1'b0, syncm: 1'b0, pol1: 1'b0, pol2: 1'b0, ovl: 1'b0, mode: 4'd0
    };

endpackage

// File: rtl/vout_cfg_reg.sv
// Configuration register: holds the control word fields.
// Assumes: hardware reset loads the fixed defaults; a soft reset is just a
// stored bit and never alters the other fields.
module vout_cfg_reg
    import vout_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [CFG_W-1:0]     wfield,
    output vout_cfg_t            cfg
);

    // Capture the configuration on a control-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_HW_DEFAULT;
        end else if (wr) begin
            cfg <= vout_cfg_t'(wfield);
        end
    end

endmodule

// File: rtl/vout_stab_gate.sv
// Enable register with stabilization gating after a soft reset.
// Assumes: soft_rst is the registered reset bit; counting starts at the edge
// where it clears and the enable is released STAB_CYCLES edges later.
module vout_stab_gate #(
    parameter int STAB_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic en_wr,
    input  logic en_bit,
    output logic en_reg,
    output logic stable,
    output logic engine_en
);

    localparam int CNT_W = $clog2(STAB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STAB_CYCLES);

    logic [CNT_W-1:0] cnt;

    // Stabilization countdown: loaded while in soft reset, drained afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (soft_rst) begin
            cnt <= CNT_LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Software enable bit, kept through soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_reg <= 1'b0;
        end else if (en_wr) begin
            en_reg <= en_bit;
        end
    end

    // Gate the enable until the engine is out of reset and settled.
    always_comb begin
        stable    = !soft_rst && (cnt == '0);
        engine_en = en_reg && stable;
    end

endmodule

// File: rtl/vout_flag_bank.sv
// Bank of sticky flags with set pulses and clear acknowledges.
// Assumes: clear wins over set; hold forces the reset value every cycle.
module vout_flag_bank #(
    parameter int              N         = 4,
    parameter logic [N-1:0]    RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        // One sticky flag: reset/hold, then clear, then set.
        always_ff @(posedge clk) begin
            if (!rst_n || hold) begin
                flags[g] <= RESET_VAL[g];
            end else if (clr[g]) begin
                flags[g] <= 1'b0;
            end else if (set[g]) begin
                flags[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/vout_ctrl_regs.sv
// Top: register decode, mode-dependent acknowledges, read mux, frame
// reference edge detection and configuration output decode.
// Assumes: all inputs are synchronous to clk; rdata is combinational.
module vout_ctrl_regs
    import vout_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int STAB_CYCLES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [1:0]        buf_done,
    input  logic              hbe_evt,
    input  logic              urun_evt,
    input  logic              io2_in,
    output logic [3:0]        mode,
    output logic [1:0]        clk_sel,
    output logic              pll_bypass,
    output logic [3:0]        pll_in_ratio,
    output logic [3:0]        pll_fb_ratio,
    output logic              clk_pin_oe,
    output logic              io_pins_oe,
    output logic              overlay_en,
    output logic              sleepless,
    output logic              soft_rst,
    output logic              engine_en,
    output logic              frame_ref,
    output logic [1:0]        buf_empty,
    output logic [1:0]        irq_buf,
    output logic              irq_hbe,
    output logic              irq_urun
);

    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(REG_CTL);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(REG_EN);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
    localparam int STAT_PAD = REG_W - NFLAG - 1;

    vout_cfg_t        cfg;
    logic             ctl_wr, en_wr, en_ack, is_msg, is_stream;
    logic             en_reg, stable;
    logic [NFLAG-1:0] flag_set, flag_clr, flags;
    logic             io2_d;

    // Decode writes and the mode-dependent acknowledge sources.
    always_comb begin
        ctl_wr    = wr_en && (addr == A_CTL);
        en_wr     = wr_en && (addr == A_EN);
        en_ack    = en_wr && wdata[0];
        is_msg    = (cfg.mode == MODE_MSG);
        is_stream = (cfg.mode == MODE_STREAM);

        flag_clr[FLG_BUF1] = (ctl_wr && wdata[ACK_BUF1])
                           || (en_ack && (is_msg || is_stream));
        flag_clr[FLG_BUF2] = (ctl_wr && wdata[ACK_BUF2] && !is_msg)
                           || (en_ack && is_stream);
        flag_clr[FLG_HBE]  = ctl_wr && wdata[ACK_HBE];
        flag_clr[FLG_URUN] = ctl_wr && wdata[ACK_URUN];

        flag_set = {urun_evt, hbe_evt, buf_done};
    end

    vout_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctl_wr),
        .wfield (wdata[REG_W-1:CFG_LSB]),
        .cfg    (cfg)
    );

    vout_stab_gate #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (cfg.srst),
        .en_wr     (en_wr),
        .en_bit    (wdata[0]),
        .en_reg    (en_reg),
        .stable    (stable),
        .engine_en (engine_en)
    );

    vout_flag_bank #(.N(NFLAG), .RESET_VAL(FLAG_RESET)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (cfg.srst),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flags)
    );

    // Previous level of the frame reference pin for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io2_d <= 1'b0;
        end else begin
            io2_d <= io2_in;
        end
    end

    // Register read multiplexer.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_CTL:   rdata = {cfg, {CFG_LSB{1'b0}}};
                A_EN:    rdata = {{(REG_W-1){1'b0}}, en_reg};
                A_STAT:  rdata = {{STAT_PAD{1'b0}}, stable, flags};
                default: rdata = '0;
            endcase
        end
    end

    // Configuration output decode and interrupt lines.
    always_comb begin
        mode         = cfg.mode;
        clk_sel      = cfg.csel;
        pll_bypass   = (cfg.csel == CSRC_SYNT);
        pll_in_ratio = {1'b0, cfg.idiv} + 4'd1;
        pll_fb_ratio = {1'b0, cfg.fdiv} + 4'd1;
        clk_pin_oe   = cfg.clkout;
        io_pins_oe   = cfg.syncm;
        overlay_en   = cfg.ovl;
        sleepless    = cfg.sleepless;
        soft_rst     = cfg.srst;
        frame_ref    = !cfg.syncm && (cfg.pol2 ? (io2_in && !io2_d)
                                               : (!io2_in && io2_d));
        buf_empty    = flags[FLG_BUF2:FLG_BUF1];
        irq_buf      = buf_empty & {2{engine_en}};
        irq_hbe      = flags[FLG_HBE];
        irq_urun     = flags[FLG_URUN];
    end

endmodule

// File: rtl/vout_ctrl_regs_chk.sv
// Checker: temporal properties of the control register unit, bound to the top.
// Assumes: it sees only ports of vout_ctrl_regs.
module vout_ctrl_regs_chk
    import vout_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int STAB_CYCLES = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [3:0]        mode,
    input logic [1:0]        clk_sel,
    input logic              clk_pin_oe,
    input logic              io_pins_oe,
    input logic              soft_rst,
    input logic              engine_en,
    input logic [1:0]        buf_done,
    input logic [1:0]        buf_empty,
    input logic              irq_hbe,
    input logic              irq_urun
);

    localparam int CW = $clog2(STAB_CYCLES + 1) + 1;
    localparam logic [CW-1:0] SMAX = CW'(STAB_CYCLES);

    logic [CW-1:0] since_rel;

    // Cycles since soft reset was last seen, saturating at the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rel <= SMAX;
        end else if (soft_rst) begin
            since_rel <= '0;
        end else if (since_rel < SMAX) begin
            since_rel <= since_rel + 1'b1;
        end
    end

    a_r1_hw_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (clk_sel == 2'd3 && !clk_pin_oe && !io_pins_oe && !soft_rst));

    a_r7_no_early_enable: assert property (@(posedge clk) disable iff (!rst_n)
        engine_en |-> (since_rel >= SMAX));

    a_r6_reset_blocks_enable: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> !engine_en);

    a_r12_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(REG_CTL) && wdata[ACK_BUF1] && !soft_rst
         && !wdata[31]) |=> !buf_empty[0]);

    a_r12_set_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty[0]) |-> ($past(buf_done[0]) || $past(soft_rst)));

    a_r10_msg_keeps_buf2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == MODE_MSG && buf_empty[1]) |=> buf_empty[1]);

    a_r11_hbe_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(REG_CTL) && wdata[ACK_HBE] && !soft_rst
         && !wdata[31]) |=> !irq_hbe);

    a_r11_urun_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(REG_CTL) && wdata[ACK_URUN] && !soft_rst
         && !wdata[31]) |=> !irq_urun);

endmodule

bind vout_ctrl_regs vout_ctrl_regs_chk #(.ADDR_W(ADDR_W), .STAB_CYCLES(STAB_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .mode       (mode),
    .clk_sel    (clk_sel),
    .clk_pin_oe (clk_pin_oe),
    .io_pins_oe (io_pins_oe),
    .soft_rst   (soft_rst),
    .engine_en  (engine_en),
    .buf_done   (buf_done),
    .buf_empty  (buf_empty),
    .irq_hbe    (irq_hbe),
    .irq_urun   (irq_urun)
);

// File: tb/test_vout_ctrl_regs.sv
`timescale 1ns/1ps
module test_vout_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [1:0]  buf_done = '0;
    logic        hbe_evt = 1'b0, urun_evt = 1'b0, io2_in = 1'b0;
    logic [3:0]  mode, pll_in_ratio, pll_fb_ratio;
    logic [1:0]  clk_sel, buf_empty, irq_buf;
    logic        pll_bypass, clk_pin_oe, io_pins_oe, overlay_en, sleepless;
    logic        soft_rst, engine_en, frame_ref, irq_hbe, irq_urun;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    vout_ctrl_regs i_vout_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .buf_done(buf_done), .hbe_evt(hbe_evt),
        .urun_evt(urun_evt), .io2_in(io2_in), .mode(mode), .clk_sel(clk_sel),
        .pll_bypass(pll_bypass), .pll_in_ratio(pll_in_ratio),
        .pll_fb_ratio(pll_fb_ratio), .clk_pin_oe(clk_pin_oe),
        .io_pins_oe(io_pins_oe), .overlay_en(overlay_en), .sleepless(sleepless),
        .soft_rst(soft_rst), .engine_en(engine_en), .frame_ref(frame_ref),
        .buf_empty(buf_empty), .irq_buf(irq_buf), .irq_hbe(irq_hbe),
        .irq_urun(irq_urun)
    );

    // Control words for the field readback walk (bit 31 kept clear)
    localparam logic [31:0] VEC [6] = '{
        32'h0000_0000, 32'h7FFF_FFFF, 32'h10A9_A00F,
        32'h2E40_0000, 32'h1D6A_8005, 32'h3240_0000
    };
    localparam logic [31:0] RD_MASK = 32'hFFFF_E000;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [1:0] bd, input logic h, input logic u);
        @(negedge clk);
        buf_done = bd; hbe_evt = h; urun_evt = u;
        @(negedge clk);
        buf_done = '0; hbe_evt = 1'b0; urun_evt = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, r); check(r == 32'h3240_0000, "R1 ctl", r, 32'h3240_0000);
        rd(2'd1, r); check(r == 32'h0, "R1 en", r, 32'h0);
        rd(2'd2, r); check(r == 32'h13, "R1 status", r, 32'h13);
        check(clk_sel == 2'd3 && pll_in_ratio == 4'd2 && pll_fb_ratio == 4'd2,
              "R1 clock outputs", {clk_sel, pll_in_ratio, pll_fb_ratio}, {2'd3, 4'd2, 4'd2});
        check(!clk_pin_oe && !io_pins_oe && !soft_rst, "R1 pins",
              {clk_pin_oe, io_pins_oe, soft_rst}, 3'b000);

        // R2 R3 R4 table walk
        for (int i = 0; i < 6; i++) begin
            logic [31:0] v;
            v = VEC[i];
            wr(2'd0, v);
            rd(2'd0, r);
            check(r == (v & RD_MASK), "R2 readback", r, v & RD_MASK);
            check(pll_in_ratio == {1'b0, v[27:25]} + 4'd1, "R3 in ratio",
                  pll_in_ratio, {1'b0, v[27:25]} + 4'd1);
            check(pll_fb_ratio == {1'b0, v[24:22]} + 4'd1, "R3 fb ratio",
                  pll_fb_ratio, {1'b0, v[24:22]} + 4'd1);
            check(clk_sel == v[29:28] && pll_bypass == (v[29:28] == 2'd3),
                  "R3 clock select", {clk_sel, pll_bypass}, {v[29:28], v[29:28] == 2'd3});
            check(clk_pin_oe == v[21] && io_pins_oe == v[20], "R4 pin oe",
                  {clk_pin_oe, io_pins_oe}, {v[21], v[20]});
        end

        // R5 frame reference edge selection
        wr(2'd0, 32'h0004_0000);
        @(negedge clk); io2_in = 1'b1;
        #1 check(frame_ref == 1'b1, "R5 rising", frame_ref, 1);
        @(negedge clk); #1 check(frame_ref == 1'b0, "R5 one cycle", frame_ref, 0);
        io2_in = 1'b0;
        #1 check(frame_ref == 1'b0, "R5 falling ignored", frame_ref, 0);
        wr(2'd0, 32'h0000_0000);
        io2_in = 1'b1;
        #1 check(frame_ref == 1'b0, "R5 rising ignored", frame_ref, 0);
        @(negedge clk); io2_in = 1'b0;
        #1 check(frame_ref == 1'b1, "R5 falling", frame_ref, 1);
        wr(2'd0, 32'h0014_0000);
        io2_in = 1'b1;
        #1 check(frame_ref == 1'b0 && io_pins_oe, "R5 master", {frame_ref, io_pins_oe}, 2'b01);
        @(negedge clk); io2_in = 1'b0;

        // R6 R7 soft reset and stabilization, streaming mode
        wr(2'd0, 32'h8000_A000);
        check(soft_rst == 1'b1, "R6 soft_rst", soft_rst, 1);
        rd(2'd0, r); check(r == 32'h8000_A000, "R6 fields kept", r, 32'h8000_A000);
        rd(2'd2, r); check(r == 32'h03, "R6 flags restored", r, 32'h03);
        pulse(2'b00, 1'b1, 1'b0);
        check(irq_hbe == 1'b0, "R6 event ignored", irq_hbe, 0);
        wr(2'd1, 32'h1);
        check(engine_en == 1'b0, "R6 enable held", engine_en, 0);
        wr(2'd0, 32'h0000_A000);
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            check(engine_en == (i == 5), "R7 stabilization", engine_en, i == 5);
        end
        rd(2'd0, r); check(r == 32'h0000_A000, "R6 value after release", r, 32'h0000_A000);
        rd(2'd2, r); check(r == 32'h13, "R7 stable status", r, 32'h13);
        check(irq_buf == 2'b11, "R13 irq enabled", irq_buf, 2'b11);

        // R9 streaming enable acknowledges both
        wr(2'd1, 32'h1);
        check(buf_empty == 2'b00 && irq_buf == 2'b00, "R9 stream ack", buf_empty, 2'b00);
        // R12 completion sets, ack wins
        pulse(2'b01, 1'b0, 1'b0);
        check(buf_empty == 2'b01, "R12 done sets", buf_empty, 2'b01);
        @(negedge clk);
        buf_done = 2'b01; wr_en = 1'b1; addr = 2'd0; wdata = 32'h0000_A001;
        @(negedge clk);
        buf_done = '0; wr_en = 1'b0; wdata = '0;
        check(buf_empty == 2'b00, "R12 ack wins", buf_empty, 2'b00);
        // R8 zero ack no effect, one clears
        pulse(2'b10, 1'b0, 1'b0);
        wr(2'd0, 32'h0000_A000);
        check(buf_empty == 2'b10, "R8 zero ack", buf_empty, 2'b10);
        wr(2'd0, 32'h0000_A002);
        check(buf_empty == 2'b00, "R8 ack clears", buf_empty, 2'b00);

        // R9 R10 message mode
        wr(2'd0, 32'h0000_8000);
        pulse(2'b11, 1'b0, 1'b0);
        wr(2'd1, 32'h1);
        check(buf_empty == 2'b10, "R9 msg ack buf1", buf_empty, 2'b10);
        wr(2'd0, 32'h0000_8002);
        check(buf_empty == 2'b10, "R10 buf2 ack ignored", buf_empty, 2'b10);
        // R9 other mode: enable write acknowledges nothing
        wr(2'd0, 32'h0000_0000);
        pulse(2'b01, 1'b0, 1'b0);
        wr(2'd1, 32'h1);
        check(buf_empty == 2'b11, "R9 other mode", buf_empty, 2'b11);

        // R11 error flags
        pulse(2'b00, 1'b1, 1'b0);
        pulse(2'b00, 1'b0, 1'b1);
        rd(2'd2, r); check(r[3:2] == 2'b11 && irq_hbe && irq_urun, "R11 set", r, 32'h1F);
        wr(2'd0, 32'h0000_0004);
        check(!irq_hbe && irq_urun, "R11 hbe ack", {irq_hbe, irq_urun}, 2'b01);
        @(negedge clk);
        urun_evt = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 32'h0000_0008;
        @(negedge clk);
        urun_evt = 1'b0; wr_en = 1'b0; wdata = '0;
        check(!irq_urun, "R11 ack wins", irq_urun, 0);

        // R13 interrupt gated by enable
        wr(2'd1, 32'h0);
        check(irq_buf == 2'b00 && buf_empty == 2'b11, "R13 gated",
              {irq_buf, buf_empty}, 4'b0011);

        // R14 unused address
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, r); check(r == 32'h0, "R14 read zero", r, 32'h0);
        rd(2'd0, r); check(r == 32'h0, "R14 ctl untouched", r, 32'h0);
        rd(2'd1, r); check(r == 32'h0, "R14 en untouched", r, 32'h0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule